// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A free-running oversampling strobe, sixteen pulses per bit, paces it; it hunts for a falling edge and confirms the start bit half a bit later. It then samples each data bit, an optional parity bit and the first stop bit at their centres. The character length, parity mode and stop length come from a run-time frame configuration word. That word is latched when a start bit is detected, so a change takes effect on the next character.

Each finished character is packed into a 16-bit word together with its parity and framing error flags, then pushed into a two-entry buffer. The buffer is read through a valid/ready stream. `rd_valid` is high while any entry is stored, and `rd_word` shows the oldest entry. A cycle with both `rd_valid` and `rd_ready` high removes that entry. While `rd_ready` is low, nothing is removed and the line keeps being received. If a character finishes while both entries are occupied and no read happens in that cycle, the character is lost and a sticky overflow flag is raised. Single-cycle command strobes switch reception on and off.

Top module: `uart_rx_path`

## Requirements
- R1: The frame word `frame_cfg` holds the data-length code in bits [3:0], and the number of data bits is the code plus 3. Codes 1 to 6 select 4 to 9 bits. A code below 1 acts as 1 and a code above 6 acts as 6.
- R2: The data bits are received least significant first and appear in `rd_word[8:0]`, with bits above the configured length reading zero. `rd_word[13:9]` always read zero.
- R3: `frame_cfg[9:8]` selects parity: 0 or 1 gives none, 2 gives even, 3 gives odd. When parity is enabled and the received parity bit does not match, `rd_word[14]` is set.
- R4: `rd_word[15]` (framing error) is set when the first stop bit is sampled low. `frame_cfg[13:12]` = 0 selects a half stop bit, which is sampled 4 ticks into it; any other code samples it at tick 8. A second stop bit is never checked, so a start bit may follow the first stop bit directly.
- R5: A line held low for a whole frame (a break) yields one word with the framing flag set and all data bits zero.
- R6: The buffer holds two words in arrival order. `rd_valid` is high while at least one is stored, and a cycle with `rd_valid` and `rd_ready` both high removes the oldest.
- R7: A character that finishes while the buffer is full (and no read in that cycle) is dropped and sets `ovf_flag`. `ovf_flag` stays set until an `ovf_clr` strobe.
- R8: A start bit is accepted only if the line is still low at the 8th tick after the falling edge is detected; a shorter low pulse is ignored.
- R9: `cmd_en` turns reception on and `cmd_dis` turns it off, with `cmd_dis` winning if both are high. While off, the line is ignored. `cmd_dis` abandons a character in progress without storing it.
- R10: After a framing error the receiver waits for the line to go high before it looks for a new start bit.
- R11: After reset, reception is off, the buffer is empty and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| frame_cfg | input | 16 | Frame word: length [3:0], parity [9:8], stop [13:12] |
| cmd_en | input | 1 | Strobe: turn reception on |
| cmd_dis | input | 1 | Strobe: turn reception off and abort frame |
| rd_valid | output | 1 | Buffer holds at least one word |
| rd_ready | input | 1 | Consumer takes the word shown this cycle |
| rd_word | output | 16 | Oldest word: data [8:0], parity error [14], framing error [15] |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Strobe: clear overflow flag |
| rx_on | output | 1 | Reception is enabled |

## Verification
The bench builds the block with its defaults: a two-stage input synchronizer, 16 ticks per bit and a two-entry buffer. The strobe is fed every fourth clock, so a bit lasts 64 clocks. With these values, three back-to-back characters reach the overflow case, and a three-tick glitch reaches the start-bit rejection case. Random characters across every length from 5 to 9 bits and all parity modes are checked together with deliberate parity corruption. Directed cases cover a break, a half stop bit, a start bit that directly follows the first of two stop bits, and an abort by the disable strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 9;
  localparam int PERR_BIT = 14;
  localparam int FERR_BIT = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [3:0] len_code;
    logic [1:0] par;
    logic [1:0] stop;
  } rx_cfg_t;

  // Number of data bits for a length code, saturated to 4..9.
  function automatic logic [3:0] rx_nbits(input logic [3:0] code);
    if (code < 4'd1) return 4'd4;
    else if (code > 4'd6) return 4'd9;
    else return code + 4'd3;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  rx_cfg_t           cfg,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  output logic              push,
  output logic [WORD_W-1:0] word,
  output logic              rx_on
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int QTR = OSR / 4;

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [3:0]        idx;
  logic [DATA_W-1:0] data;
  logic              pbit;
  rx_cfg_t           cfg_q;
  logic [3:0]        nbits;
  logic              mid_hit, stop_hit, perr;

  assign nbits    = rx_nbits(cfg_q.len_code);
  assign mid_hit  = tick && (cnt == CW'(MID - 1));
  assign stop_hit = tick && ((cfg_q.stop == 2'd0) ? (cnt == CW'(QTR - 1)) : (cnt == CW'(MID - 1)));
  assign perr     = cfg_q.par[1] && ((^data ^ pbit) != cfg_q.par[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      data  <= '0;
      pbit  <= 1'b0;
      cfg_q <= '0;
      rx_on <= 1'b0;
      push  <= 1'b0;
      word  <= '0;
    end else begin
      push <= 1'b0;
      if (cmd_dis) rx_on <= 1'b0;
      else if (cmd_en) rx_on <= 1'b1;

      if (cmd_dis || !rx_on) begin
        state <= ST_IDLE;
      end else begin
        if (tick) cnt <= cnt + 1'b1;
        unique case (state)
          ST_IDLE: if (tick && !line) begin
            state <= ST_START;
            cnt   <= CW'(1);
            cfg_q <= cfg;
            data  <= '0;
            idx   <= '0;
          end
          ST_START: if (mid_hit) state <= line ? ST_IDLE : ST_DATA;
          ST_DATA: if (mid_hit) begin
            data[idx] <= line;
            idx       <= idx + 1'b1;
            if (idx == nbits - 1'b1) state <= cfg_q.par[1] ? ST_PAR : ST_STOP;
          end
          ST_PAR: if (mid_hit) begin
            pbit  <= line;
            state <= ST_STOP;
          end
          ST_STOP: if (stop_hit) begin
            push  <= 1'b1;
            word  <= '0;
            word[DATA_W-1:0] <= data;
            word[PERR_BIT]   <= perr;
            word[FERR_BIT]   <= !line;
            state <= line ? ST_IDLE : ST_WAITHI;
          end
          ST_WAITHI: if (line) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: a disable strobe leaves the receiver idle and off
  a_r9_dis_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> (state == ST_IDLE) && !rx_on);

  // R10: while waiting for the line to rise, a low line holds the wait
  a_r10_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITHI) && !line && rx_on && !cmd_dis |=> state == ST_WAITHI);

  // R2: stored data never has bits above the configured length
  a_r2_data_width: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((word[DATA_W-1:0] >> nbits) == '0));
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DEPTH = 2,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_pop, do_push;

  assign valid   = (count != '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && valid;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp      <= nxt(wp);
      end
      if (do_pop) rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6: a read without a write removes exactly one entry
  a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && !push |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [15:0]       frame_cfg,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_word,
  output logic              ovf_flag,
  input  logic              ovf_clr,
  output logic              rx_on
);
  logic              line;
  logic              f_push, b_full;
  logic [WORD_W-1:0] f_word;
  rx_cfg_t           cfg;
  logic              unused_cfg_bits;

  assign cfg.len_code   = frame_cfg[3:0];
  assign cfg.par        = frame_cfg[9:8];
  assign cfg.stop       = frame_cfg[13:12];
  assign unused_cfg_bits = ^{frame_cfg[15:14], frame_cfg[11:10], frame_cfg[7:4]};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line)
  );

  uart_rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .cfg(cfg),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .push(f_push), .word(f_word),
    .rx_on(rx_on)
  );

  uart_rx_buf #(.DEPTH(DEPTH), .W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(f_push), .din(f_word),
    .pop(rd_ready), .dout(rd_word), .valid(rd_valid), .full(b_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ovf_flag <= 1'b0;
    else if (f_push && b_full && !rd_ready)      ovf_flag <= 1'b1;
    else if (ovf_clr)                            ovf_flag <= 1'b0;
  end

  // R7: a character arriving at a full buffer raises the overflow flag
  a_r7_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    f_push && b_full && !rd_ready |=> ovf_flag);

  // R7: the flag is sticky without a clear strobe
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
endmodule

// File: tb/sim_uart_rx_path.sv
module sim_uart_rx_path;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLK    = 16 * TICK_DIV;

  logic        clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic [15:0] frame_cfg = '0;
  logic        cmd_en = 1'b0, cmd_dis = 1'b0, rd_ready = 1'b0, ovf_clr = 1'b0;
  logic        rd_valid, ovf_flag, rx_on;
  logic [15:0] rd_word;
  int          n_tests = 0, n_fail = 0;
  int          tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  uart_rx_path u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .frame_cfg(frame_cfg), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_word(rd_word),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .rx_on(rx_on)
  );

  function automatic logic [15:0] mk_cfg(input int len, input int par, input int stp);
    return {2'b00, 2'(stp), 2'b00, 2'(par), 4'b0000, 4'(len - 3)};
  endfunction

  function automatic logic [15:0] exp_word(input logic [8:0] d, input int nb,
                                           input bit perr, input bit ferr);
    logic [8:0] m;
    m = d & 9'((1 << nb) - 1);
    return {ferr, perr, 5'b0, m};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int bits);
    rxd = v;
    repeat (bits * BIT_CLK) @(negedge clk);
  endtask

  // start, data LSB first, optional parity, one stop bit at stop_lvl
  task automatic send(input logic [8:0] d, input int nb, input int par,
                      input bit bad_par, input bit stop_lvl);
    logic p;
    hold(1'b0, 1);
    for (int i = 0; i < nb; i++) hold(d[i], 1);
    if (par >= 2) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      if (par == 3) p = ~p;
      hold(p ^ bad_par, 1);
    end
    hold(stop_lvl, 1);
  endtask

  task automatic read_check(input string req, input logic [15:0] exp);
    @(negedge clk);
    check({req, " valid"}, {31'b0, rd_valid}, 32'd1);
    check({req, " word"}, {16'b0, rd_word}, {16'b0, exp});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] d;
    int nb, par;
    bit bad;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 rx_on", {31'b0, rx_on}, 0);
    check("R11 rd_valid", {31'b0, rd_valid}, 0);
    check("R11 ovf_flag", {31'b0, ovf_flag}, 0);
    rst_n = 1'b1;
    // R9: disabled receiver ignores a frame
    frame_cfg = mk_cfg(8, 0, 1);
    send(9'h0A5, 8, 0, 0, 1); hold(1'b1, 1);
    check("R9 disabled ignores line", {31'b0, rd_valid}, 0);
    pulse(cmd_en);
    @(negedge clk);
    check("R9 rx_on after enable", {31'b0, rx_on}, 1);
    hold(1'b1, 1);

    // R1 R2 R3: random characters over all lengths and parity modes
    for (int i = 0; i < 40; i++) begin
      nb  = 5 + int'($urandom_range(0, 4));
      par = int'($urandom_range(0, 2));
      if (par != 0) par = par + 1;
      bad = ($urandom_range(0, 3) == 0);
      d   = 9'($urandom);
      frame_cfg = mk_cfg(nb, par, 1);
      send(d, nb, par, bad, 1'b1);
      hold(1'b1, 1);
      read_check("R1 R2 R3 random char", exp_word(d, nb, bad && par >= 2, 1'b0));
      check("R6 empty after read", {31'b0, rd_valid}, 0);
    end

    // R4: framing error, half stop bit and second stop not checked
    frame_cfg = mk_cfg(8, 0, 1);
    send(9'h03C, 8, 0, 0, 1'b0); hold(1'b1, 1);
    read_check("R4 framing error", exp_word(9'h03C, 8, 0, 1));
    frame_cfg = mk_cfg(7, 2, 0);
    send(9'h055, 7, 2, 0, 1'b1); hold(1'b1, 1);
    read_check("R4 half stop bit", exp_word(9'h055, 7, 0, 0));
    frame_cfg = mk_cfg(8, 0, 3);
    send(9'h0C3, 8, 0, 0, 1'b1);
    send(9'h018, 8, 0, 0, 1'b1); hold(1'b1, 1);
    read_check("R4 first of back-to-back", exp_word(9'h0C3, 8, 0, 0));
    read_check("R4 second stop unchecked", exp_word(9'h018, 8, 0, 0));

    // R5 R10: break, then receiver waits for high line
    frame_cfg = mk_cfg(8, 0, 1);
    hold(1'b0, 25);
    hold(1'b1, 1);
    read_check("R5 break word", 16'h8000);
    check("R10 single word during break", {31'b0, rd_valid}, 0);
    send(9'h07E, 8, 0, 0, 1'b1); hold(1'b1, 1);
    read_check("R10 resumes after high", exp_word(9'h07E, 8, 0, 0));

    // R8: short low glitch is not a start bit
    rxd = 1'b0; repeat (3 * TICK_DIV) @(negedge clk);
    hold(1'b1, 12);
    check("R8 glitch ignored", {31'b0, rd_valid}, 0);

    // R6 R7: overflow with back-pressure
    send(9'h011, 8, 0, 0, 1'b1);
    send(9'h022, 8, 0, 0, 1'b1);
    hold(1'b1, 1);
    check("R7 no overflow at two", {31'b0, ovf_flag}, 0);
    send(9'h033, 8, 0, 0, 1'b1); hold(1'b1, 1);
    check("R7 overflow flag set", {31'b0, ovf_flag}, 1);
    read_check("R6 order first", exp_word(9'h011, 8, 0, 0));
    read_check("R6 order second", exp_word(9'h022, 8, 0, 0));
    check("R7 third char dropped", {31'b0, rd_valid}, 0);
    check("R7 flag sticky", {31'b0, ovf_flag}, 1);
    pulse(ovf_clr);
    @(negedge clk);
    check("R7 flag cleared", {31'b0, ovf_flag}, 0);

    // R9: disable aborts a frame in progress
    hold(1'b0, 3);
    pulse(cmd_dis);
    hold(1'b1, 10);
    check("R9 aborted frame not stored", {31'b0, rd_valid}, 0);
    check("R9 rx_on off", {31'b0, rx_on}, 0);
    pulse(cmd_en);
    send(9'h099, 8, 0, 0, 1'b1); hold(1'b1, 1);
    read_check("R9 works after re-enable", exp_word(9'h099, 8, 0, 0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule